// File: doc/BRIEF.md
# Status-Coded I2C Byte Master

This block is a byte-level I2C master driven through a small register file. Software, or a local sequencer, writes a transmit byte and a control byte. Each control write that clears the interrupt flag starts exactly one bus step: a START, a repeated START, an address or data byte out, a data byte in, or a STOP. When the step finishes, the block raises the interrupt flag and posts an 8-bit status code. The bus stays frozen, with SCL held low, until the flag is cleared again.

Bit timing comes from an external strobe, `sclTick`. Each strobe advances the bit engine by one quarter of an SCL period. Both bus lines are open-drain: the block only reports when it pulls a line low, and it reads back the resolved SDA level. The receiving side decides its next step from the status code last posted. After 0x40 or 0x50 the next launch is a receive; after any other code it is a transmit. Bit 0 of a byte sent directly after a START or repeated START selects a read (1) or a write (0).

Top module: `i2c_status_master`

## Requirements
- R1: After reset the status register (regSel 2) reads 0xF8, the control register (regSel 1) reads 0x00, the data register (regSel 0) reads 0x00, `irq` is low and neither bus line is pulled low.
- R2: A control write of ENABLE (bit 6) plus START (bit 5) while idle generates a START condition, posts status 0x08 and sets the flag, which reads back as control bit 3.
- R3: A byte sent right after a START or repeated START is an address. It posts 0x18 for a write with ACK, 0x20 for a write with NAK, 0x40 for a read with ACK and 0x48 for a read with NAK.
- R4: A byte sent at any other time goes out MSB first and posts 0x28 if the target ACKs or 0x30 if it NAKs.
- R5: After 0x40 or 0x50, clearing the flag with ENABLE starts a receive. If ACK (bit 2) was set in that same write, the block ACKs the byte and posts 0x50; otherwise it NAKs and posts 0x58. The received byte reads from regSel 0.
- R6: The received byte on regSel 0 does not change until the next receive completes.
- R7: START set in the write that clears the flag during a transfer produces a repeated START and posts 0x10.
- R8: STOP (bit 4) set in the write that clears the flag produces a STOP condition. The flag is not raised. Status returns to 0xF8 and both lines are released.
- R9: While the flag is set, SCL is held low and status and bus lines stay unchanged. In the default mode, writing 1 to bit 3 keeps the flag set and starts nothing; a parameter selects write-1-to-clear instead.
- R10: `irq` is high exactly when the flag and INTEN (bit 7) are both set.
- R11: Any write to regSel 3 returns the block to its reset state, from any point of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclTick | input | 1 | Quarter-bit phase strobe |
| regSel | input | 2 | Register index: 0 data, 1 control, 2 status, 3 soft reset |
| regWr | input | 1 | Write strobe for the selected register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| sclDriveLow | output | 1 | Pull SCL low when high |
| sdaDriveLow | output | 1 | Pull SDA low when high |
| sdaIn | input | 1 | Resolved SDA level |

## Verification
The bench talks to a behavioural target on the shared wired-AND bus and goes after four things.

- Whether the status code after a byte depends on the address phase and the read/write bit. A design that tracked the address phase wrongly would post 0x28 where 0x18 belongs, or 0x18 where 0x40 belongs.
- Whether the receive ACK comes from the launching write rather than the stored ACK bit. A design that used the stored bit would ACK the last byte, and the target would keep driving SDA.
- Whether a write of 1 to the flag is treated as a launch. A design that did so would release SCL while the flag is set.
- Whether the received byte changes while the next receive is only half done, and whether a STOP or a soft reset leaves a stray flag or a line still pulled low.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  localparam int BYTE_W = 8;

  // register indices
  localparam logic [1:0] REG_DATA = 2'd0;
  localparam logic [1:0] REG_CTRL = 2'd1;
  localparam logic [1:0] REG_STAT = 2'd2;
  localparam logic [1:0] REG_RST  = 2'd3;

  // posted status codes
  localparam logic [7:0] SC_START   = 8'h08;
  localparam logic [7:0] SC_RSTART  = 8'h10;
  localparam logic [7:0] SC_AW_ACK  = 8'h18;
  localparam logic [7:0] SC_AW_NAK  = 8'h20;
  localparam logic [7:0] SC_DW_ACK  = 8'h28;
  localparam logic [7:0] SC_DW_NAK  = 8'h30;
  localparam logic [7:0] SC_AR_ACK  = 8'h40;
  localparam logic [7:0] SC_AR_NAK  = 8'h48;
  localparam logic [7:0] SC_DR_ACK  = 8'h50;
  localparam logic [7:0] SC_DR_NAK  = 8'h58;
  localparam logic [7:0] SC_IDLE    = 8'hF8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_RSTART, ST_XFER, ST_STOP, ST_HOLD
  } busState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic clear;
    logic loadTx;
    logic sampleBit;
    logic shiftBit;
    logic sampleAck;
    logic doneStart;
    logic doneRstart;
    logic doneXfer;
    logic doneStop;
  } dpStrobe_t;
endpackage

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter bit IFLG_W1C = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclTick,
  input  logic       ctrlWr,
  input  logic       softRst,
  input  logic [7:2] ctrlBits,
  input  logic       txMsb,
  input  logic       rxNext,
  output dpStrobe_t  st,
  output logic       iflg,
  output logic       ackCfg,
  output logic       enCfg,
  output logic       intCfg,
  output logic       xferRx,
  output logic       xferAck,
  output logic       sclLow,
  output logic       sdaLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

  busState_t        state;
  logic [1:0]       phase;
  logic [CNT_W-1:0] bitCnt;

  logic iflgAfter, goStart, goHoldLaunch, stepEnd, sampleNow, lastBit;

  assign iflgAfter    = IFLG_W1C ? (iflg & ~ctrlBits[3]) : (iflg & ctrlBits[3]);
  assign goStart      = ctrlWr && ctrlBits[6] && ctrlBits[5] && state == ST_IDLE;
  assign goHoldLaunch = ctrlWr && ctrlBits[6] && !iflgAfter && state == ST_HOLD;
  assign stepEnd      = sclTick && phase == 2'd3;
  assign sampleNow    = sclTick && phase == 2'd2;
  assign lastBit      = bitCnt == LAST_BIT;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; phase <= 2'd0; bitCnt <= '0; iflg <= 1'b0;
      ackCfg <= 1'b0; enCfg <= 1'b0; intCfg <= 1'b0;
      xferRx <= 1'b0; xferAck <= 1'b0;
    end else if (softRst) begin
      state <= ST_IDLE; phase <= 2'd0; bitCnt <= '0; iflg <= 1'b0;
      ackCfg <= 1'b0; enCfg <= 1'b0; intCfg <= 1'b0;
      xferRx <= 1'b0; xferAck <= 1'b0;
    end else begin
      if (ctrlWr) begin
        ackCfg <= ctrlBits[2];
        enCfg  <= ctrlBits[6];
        intCfg <= ctrlBits[7];
        iflg   <= iflgAfter;
      end
      unique case (state)
        ST_IDLE: if (goStart) begin state <= ST_START; phase <= 2'd0; end
        ST_HOLD: if (goHoldLaunch) begin
          phase <= 2'd0;
          if (ctrlBits[5])      state <= ST_RSTART;
          else if (ctrlBits[4]) state <= ST_STOP;
          else begin
            state   <= ST_XFER;
            bitCnt  <= '0;
            xferRx  <= rxNext;
            xferAck <= ctrlBits[2];
          end
        end
        default: if (sclTick) begin
          phase <= phase + 2'd1;
          if (stepEnd) begin
            if (state == ST_STOP) state <= ST_IDLE;
            else if (state == ST_XFER && !lastBit) bitCnt <= bitCnt + CNT_W'(1);
            else begin state <= ST_HOLD; iflg <= 1'b1; end
          end
        end
      endcase
    end
  end

  always_comb begin
    st            = '0;
    st.clear      = softRst;
    st.loadTx     = goHoldLaunch && !ctrlBits[5] && !ctrlBits[4];
    st.sampleBit  = state == ST_XFER && sampleNow && !lastBit;
    st.shiftBit   = state == ST_XFER && stepEnd && !lastBit;
    st.sampleAck  = state == ST_XFER && sampleNow && lastBit;
    st.doneStart  = state == ST_START && stepEnd;
    st.doneRstart = state == ST_RSTART && stepEnd;
    st.doneXfer   = state == ST_XFER && stepEnd && lastBit;
    st.doneStop   = state == ST_STOP && stepEnd;
  end

  // open-drain line pattern per step and quarter phase
  always_comb begin
    sclLow = 1'b0;
    sdaLow = 1'b0;
    unique case (state)
      ST_HOLD:   sclLow = 1'b1;
      ST_START:  begin sdaLow = phase != 2'd0; sclLow = phase[1]; end
      ST_RSTART: begin sclLow = phase == 2'd0 || phase == 2'd3; sdaLow = phase[1]; end
      ST_STOP:   begin sclLow = phase == 2'd0; sdaLow = !phase[1]; end
      ST_XFER: begin
        sclLow = phase == 2'd0 || phase == 2'd3;
        sdaLow = lastBit ? (xferRx & xferAck) : (!xferRx & !txMsb);
      end
      default: ;
    endcase
  end

  // R9: a posted flag keeps the clock line pulled low
  a_r9_hold_scl: assert property (@(posedge clk) disable iff (!rstN)
    iflg |-> sclLow);
  // R8: a STOP step never posts the flag
  a_r8_stop_no_flag: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_STOP |=> !iflg);
endmodule

// File: rtl/i2cm_dp.sv
module i2cm_dp
  import i2cm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         st,
  input  logic              dataWr,
  input  logic [BYTE_W-1:0] wrData,
  input  logic              sdaIn,
  input  logic              xferRx,
  input  logic              xferAck,
  output logic              txMsb,
  output logic              rxNext,
  output logic [7:0]        status,
  output logic [BYTE_W-1:0] rxByte
);
  logic [BYTE_W-1:0] txByte, shiftReg;
  logic sampled, ackSeen, isAddr, isRead;

  assign txMsb  = shiftReg[BYTE_W-1];
  assign rxNext = status == SC_AR_ACK || status == SC_DR_ACK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txByte <= '0; shiftReg <= '0; rxByte <= '0; status <= SC_IDLE;
      sampled <= 1'b0; ackSeen <= 1'b0; isAddr <= 1'b0; isRead <= 1'b0;
    end else if (st.clear) begin
      txByte <= '0; shiftReg <= '0; rxByte <= '0; status <= SC_IDLE;
      sampled <= 1'b0; ackSeen <= 1'b0; isAddr <= 1'b0; isRead <= 1'b0;
    end else begin
      if (dataWr) txByte <= wrData;
      if (st.loadTx) begin
        shiftReg <= txByte;
        isAddr   <= status == SC_START || status == SC_RSTART;
        isRead   <= txByte[0];
      end
      if (st.sampleBit) sampled  <= sdaIn;
      if (st.shiftBit)  shiftReg <= {shiftReg[BYTE_W-2:0], sampled};
      if (st.sampleAck) ackSeen  <= !sdaIn;
      if (st.doneStart)  status <= SC_START;
      if (st.doneRstart) status <= SC_RSTART;
      if (st.doneStop)   status <= SC_IDLE;
      if (st.doneXfer) begin
        if (xferRx) begin
          rxByte <= shiftReg;
          status <= xferAck ? SC_DR_ACK : SC_DR_NAK;
        end else if (isAddr) begin
          if (isRead) status <= ackSeen ? SC_AR_ACK : SC_AR_NAK;
          else        status <= ackSeen ? SC_AW_ACK : SC_AW_NAK;
        end else begin
          status <= ackSeen ? SC_DW_ACK : SC_DW_NAK;
        end
      end
    end
  end

  // R6: received byte moves only when a receive completes or on soft reset
  a_r6_rx_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(st.doneXfer && xferRx) && !st.clear |=> $stable(rxByte));
  // R9: posted status moves only on a step completion or soft reset
  a_r9_status_stable: assert property (@(posedge clk) disable iff (!rstN)
    !(st.doneStart || st.doneRstart || st.doneXfer || st.doneStop || st.clear)
    |=> $stable(status));
  // R2: at most one step completes per cycle
  a_r2_one_done: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.doneStart, st.doneRstart, st.doneXfer, st.doneStop}));
endmodule

// File: rtl/i2c_status_master.sv
module i2c_status_master
  import i2cm_pkg::*;
#(
  parameter bit IFLG_W1C = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclTick,
  input  logic [1:0] regSel,
  input  logic       regWr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       irq,
  output logic       sclDriveLow,
  output logic       sdaDriveLow,
  input  logic       sdaIn
);
  dpStrobe_t         st;
  logic              ctrlWr, dataWr, softRst;
  logic              iflg, ackCfg, enCfg, intCfg, xferRx, xferAck, txMsb, rxNext;
  logic [7:0]        status;
  logic [BYTE_W-1:0] rxByte;

  assign ctrlWr  = regWr && regSel == REG_CTRL;
  assign dataWr  = regWr && regSel == REG_DATA;
  assign softRst = regWr && regSel == REG_RST;

  i2cm_ctrl #(.IFLG_W1C(IFLG_W1C)) uCtrl (
    .clk(clk), .rstN(rstN), .sclTick(sclTick), .ctrlWr(ctrlWr),
    .softRst(softRst), .ctrlBits(regWrData[7:2]), .txMsb(txMsb),
    .rxNext(rxNext), .st(st), .iflg(iflg), .ackCfg(ackCfg), .enCfg(enCfg),
    .intCfg(intCfg), .xferRx(xferRx), .xferAck(xferAck),
    .sclLow(sclDriveLow), .sdaLow(sdaDriveLow)
  );

  i2cm_dp uDp (
    .clk(clk), .rstN(rstN), .st(st), .dataWr(dataWr), .wrData(regWrData),
    .sdaIn(sdaIn), .xferRx(xferRx), .xferAck(xferAck), .txMsb(txMsb),
    .rxNext(rxNext), .status(status), .rxByte(rxByte)
  );

  always_comb begin
    unique case (regSel)
      REG_DATA: regRdData = rxByte;
      REG_CTRL: regRdData = {intCfg, enCfg, 2'b00, iflg, ackCfg, 2'b00};
      REG_STAT: regRdData = status;
      default:  regRdData = 8'h00;
    endcase
  end

  assign irq = iflg & intCfg;
endmodule

// File: tb/sim_i2c_status_master.sv
module sim_i2c_status_master;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclTick = 1'b0;
  logic [1:0] regSel = 2'd0;
  logic       regWr = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       irq, sclDriveLow, sdaDriveLow, sdaIn;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  // wired-AND bus with a behavioural target at address 0x50
  logic slvLow = 1'b0;
  logic sclLine, sdaLine;
  assign sclLine = ~sclDriveLow;
  assign sdaLine = ~(sdaDriveLow | slvLow);
  assign sdaIn   = sdaLine;

  localparam logic [6:0] SLV_ADDR = 7'h50;
  logic prevScl = 1'b1, prevSda = 1'b1;
  logic active = 0, addrPh = 0, slvRead = 0, slvSel = 0, masterAck = 0, nakData = 0;
  logic [7:0] sh = 0, lastRx = 0, curRead = 0;
  int bitIdx = 0, readIdx = 0;

  function automatic logic [7:0] rdValue(int i);
    return 8'h96 + 8'(i) * 8'h1B;
  endfunction

  always @(sclLine or sdaLine) begin
    if (sclLine && prevScl && prevSda && !sdaLine) begin
      active = 1; addrPh = 1; bitIdx = 0; slvLow = 0; slvRead = 0; slvSel = 0;
    end else if (sclLine && prevScl && !prevSda && sdaLine) begin
      active = 0; slvLow = 0;
    end else if (sclLine && !prevScl && active) begin
      if (bitIdx < 8) begin sh = {sh[6:0], sdaLine}; bitIdx++; end
      else begin masterAck = !sdaLine; bitIdx = 9; end
    end else if (!sclLine && prevScl && active) begin
      if (bitIdx == 8) begin
        if (addrPh) begin
          slvSel = sh[7:1] == SLV_ADDR; slvRead = sh[0]; slvLow = slvSel;
        end else if (!slvRead) begin
          lastRx = sh; slvLow = !nakData;
        end else slvLow = 0;
      end else if (bitIdx == 9) begin
        logic wasAddr;
        wasAddr = addrPh; addrPh = 0; bitIdx = 0;
        if (slvRead && slvSel && (wasAddr || masterAck)) begin
          curRead = rdValue(readIdx); readIdx++; slvLow = !curRead[7];
        end else slvLow = 0;
      end else if (slvRead && slvSel && !addrPh && bitIdx > 0) begin
        slvLow = !curRead[7-bitIdx];
      end
    end
    prevScl = sclLine; prevSda = sdaLine;
  end

  i2c_status_master u0 (
    .clk(clk), .rstN(rstN), .sclTick(sclTick), .regSel(regSel), .regWr(regWr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq),
    .sclDriveLow(sclDriveLow), .sdaDriveLow(sdaDriveLow), .sdaIn(sdaIn)
  );

  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % 4;
      sclTick = (tc == 0);
    end
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] sel, logic [7:0] d);
    @(negedge clk);
    regSel = sel; regWr = 1'b1; regWrData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    regSel = sel;
    #1 v = regRdData;
  endtask

  task automatic waitFlag(string req);
    logic [7:0] v;
    bit got = 0;
    for (int i = 0; i < 1000 && !got; i++) begin
      rd(2'd1, v);
      got = v[3];
    end
    if (!got) chk({req, " flag timeout"}, 8'h0, 8'h1);
  endtask

  task automatic launchAndCheck(string req, logic [7:0] ctrl, logic [7:0] expStat);
    logic [7:0] v;
    wr(2'd1, ctrl);
    waitFlag(req);
    rd(2'd2, v);
    chk(req, v, expStat);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(2'd2, v); chk("R1 status", v, 8'hF8);
    rd(2'd1, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd0, v); chk("R1 data", v, 8'h00);
    chk("R1 lines/irq", {5'b0, irq, sclDriveLow, sdaDriveLow}, 8'h00);
  endtask

  task automatic t_start_hold();
    logic [7:0] v;
    int lowCnt = 0;
    launchAndCheck("R2 start", 8'hE0, 8'h08);
    rd(2'd1, v); chk("R2 flag bit", v & 8'h08, 8'h08);
    chk("R10 irq on", {7'b0, irq}, 8'h01);
    wr(2'd1, 8'hC8);  // flag written as 1: must stay set, no launch
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (sclDriveLow) lowCnt++;
    end
    chk("R9 scl held", 8'(lowCnt), 8'd60);
    rd(2'd2, v); chk("R9 status frozen", v, 8'h08);
    rd(2'd1, v); chk("R9 flag kept", v & 8'h08, 8'h08);
    wr(2'd1, 8'h48);
    #1 chk("R10 irq off with INTEN clear", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_write();
    wr(2'd0, 8'hA0);
    launchAndCheck("R3 addr write ack", 8'h40, 8'h18);
    wr(2'd0, 8'h3C);
    launchAndCheck("R4 data ack", 8'h40, 8'h28);
    chk("R4 byte seen by target", lastRx, 8'h3C);
    nakData = 1;
    wr(2'd0, 8'h81);
    launchAndCheck("R4 data nak", 8'h40, 8'h30);
    chk("R4 byte seen by target", lastRx, 8'h81);
    nakData = 0;
  endtask

  task automatic t_read();
    logic [7:0] v;
    launchAndCheck("R7 repeated start", 8'h60, 8'h10);
    wr(2'd0, 8'hA1);
    launchAndCheck("R3 addr read ack", 8'h40, 8'h40);
    launchAndCheck("R5 recv ack", 8'h44, 8'h50);
    rd(2'd0, v); chk("R5 recv byte", v, rdValue(0));
    chk("R5 ack sent", {7'b0, masterAck}, 8'h01);
    wr(2'd1, 8'h40);
    repeat (60) @(negedge clk);
    rd(2'd0, v); chk("R6 byte stable mid-receive", v, rdValue(0));
    waitFlag("R5 recv nak");
    rd(2'd2, v); chk("R5 recv nak", v, 8'h58);
    rd(2'd0, v); chk("R5 recv byte 2", v, rdValue(1));
    chk("R5 nak sent", {7'b0, masterAck}, 8'h00);
  endtask

  task automatic t_stop();
    logic [7:0] v;
    bit flagSeen = 0, idle = 0;
    wr(2'd1, 8'h50);
    for (int i = 0; i < 200 && !idle; i++) begin
      rd(2'd1, v); if (v[3]) flagSeen = 1;
      rd(2'd2, v); idle = (v == 8'hF8);
    end
    chk("R8 idle status", v, 8'hF8);
    chk("R8 no flag", {7'b0, flagSeen}, 8'h00);
    chk("R8 lines released", {6'b0, sclDriveLow, sdaDriveLow}, 8'h00);
  endtask

  task automatic t_naks();
    launchAndCheck("R2 start again", 8'h60, 8'h08);
    wr(2'd0, 8'hC3);
    launchAndCheck("R3 addr read nak", 8'h40, 8'h48);
    launchAndCheck("R7 repeated start 2", 8'h60, 8'h10);
    wr(2'd0, 8'hC2);
    launchAndCheck("R3 addr write nak", 8'h40, 8'h20);
    t_stop();
  endtask

  task automatic t_softReset();
    logic [7:0] v;
    launchAndCheck("R2 start 3", 8'hE0, 8'h08);
    wr(2'd0, 8'hA0);
    launchAndCheck("R3 addr write ack 2", 8'h40, 8'h18);
    wr(2'd3, 8'h00);
    rd(2'd2, v); chk("R11 status", v, 8'hF8);
    rd(2'd1, v); chk("R11 ctrl", v, 8'h00);
    rd(2'd0, v); chk("R11 data", v, 8'h00);
    chk("R11 lines/irq", {5'b0, irq, sclDriveLow, sdaDriveLow}, 8'h00);
    launchAndCheck("R11 usable after reset", 8'h60, 8'h08);
    t_stop();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_start_hold();
    t_write();
    t_read();
    t_stop();
    t_naks();
    t_softReset();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule